// File: doc/BRIEF.md
# Nibble-Bus Single-Byte Write Target

This block is the target side of a 4-bit multiplexed firmware bus that moves one nibble per rising clock edge under an active-low frame strobe. It decodes single-byte memory write cycles:
- a start code, of which only the last one sent while the strobe is low counts;
- a device-select nibble that is compared against strap pins;
- a 28-bit address, most significant nibble first;
- a size nibble;
- two data nibbles.

After the data the host hands the bus over during two turn-around clocks. The target then drives a ready sync, drives all ones for one clock, and releases the bus back to the host.

The block raises a one-clock write strobe carrying the captured address and data byte, for a flash command or programming path behind it. It drives the shared bus through a separate data output and output enable. The pad-level tri-state buffer sits outside this block.

Top module: `nwt_target`

## Requirements
- R1: While reset is applied and after its release with no traffic, `bus_oe_o` and `wr_valid_o` are low.
- R2: A cycle opens on every clock where `frame_ni` is low. Only the nibble sampled on the last low-strobe clock is the start code, and only 4'hE opens a write. Any other last value makes the target ignore the cycle.
- R3: The first nibble after the strobe rises is the device select. When it differs from `strap_i`, the target does not drive and does not strobe for the rest of the cycle.
- R4: Seven address nibbles follow, most significant first. The first carries address bits 27..24 and the seventh carries bits 3..0.
- R5: The next nibble is the size and must be 4'h0. Any other value aborts the cycle with no drive and no write strobe.
- R6: Two data nibbles follow. The first is data bits 3..0 and the second is data bits 7..4.
- R7: During the two clocks after the second data nibble (host turn-around), `bus_oe_o` stays low.
- R8: On the third clock after the second data nibble, the target drives 4'h0 with `bus_oe_o` high. In that same clock it raises `wr_valid_o` for exactly one clock, with the captured address and data.
- R9: A low `frame_ni` in any clock drops the transfer in progress, and decoding restarts from the start field.
- R10: The target drives 4'hF in the clock after the ready sync and leaves `bus_oe_o` low in the clock after that. It drives in no other clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, all fields sampled and driven on rising edges |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_ni | input | 1 | Active-low frame strobe |
| bus_i | input | 4 | Resolved value of the shared nibble bus |
| strap_i | input | 4 | Device-select strap value |
| bus_o | output | 4 | Nibble driven by the target |
| bus_oe_o | output | 1 | Output enable for `bus_o` |
| wr_valid_o | output | 1 | One-clock write strobe |
| wr_addr_o | output | 28 | Captured write address |
| wr_data_o | output | 8 | Captured write byte |

## Verification
A well-formed write with a mixed address and data byte checks nibble order: a swapped data nibble or a reversed address shows up in the strobe payload. Several start nibbles in a row, ending with the write code or ending with another code, tell the last-start rule apart from a first-start or any-start rule. A mismatched select, a non-zero size and a frame strobe reasserted inside the address phase must each leave the bus undriven, and the last must be followed by a clean write. A second strap value with a matching and a non-matching select confirms that the compare tracks the pins and not a fixed code.

// File: rtl/nwt_pkg.sv
package nwt_pkg;
  typedef enum logic [3:0] {
    S_IDLE  = 4'd0,
    S_START = 4'd1,
    S_ADDR  = 4'd2,
    S_SIZE  = 4'd3,
    S_DLO   = 4'd4,
    S_DHI   = 4'd5,
    S_HTAR0 = 4'd6,
    S_HTAR1 = 4'd7,
    S_SYNC  = 4'd8,
    S_TTAR  = 4'd9
  } nwt_state_e;

  localparam logic [3:0] START_MEM_WR = 4'hE;
  localparam logic [3:0] SIZE_ONE     = 4'h0;
  localparam logic [3:0] SYNC_READY   = 4'h0;
  localparam logic [3:0] NIB_ONES     = 4'hF;
endpackage

// File: rtl/nwt_fsm.sv
module nwt_fsm
  import nwt_pkg::*;
#(
  parameter int ADDR_NIBBLES = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_ni,
  input  logic [3:0] bus_i,
  input  logic [3:0] strap_i,
  output nwt_state_e state_o
);
  localparam int CNT_W = $clog2(ADDR_NIBBLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_NIBBLES - 1);

  nwt_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [3:0] start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      start_q <= NIB_ONES;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (!frame_ni) start_q <= bus_i; // latest start nibble wins
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!frame_ni) begin
      state_d = S_START;
    end else begin
      unique case (state_q)
        S_IDLE:  state_d = S_IDLE;
        S_START: begin
          cnt_d   = '0;
          state_d = (start_q == START_MEM_WR && bus_i == strap_i) ? S_ADDR : S_IDLE;
        end
        S_ADDR: begin
          if (cnt_q == LAST) state_d = S_SIZE;
          else cnt_d = cnt_q + 1'b1;
        end
        S_SIZE:  state_d = (bus_i == SIZE_ONE) ? S_DLO : S_IDLE;
        S_DLO:   state_d = S_DHI;
        S_DHI:   state_d = S_HTAR0;
        S_HTAR0: state_d = S_HTAR1;
        S_HTAR1: state_d = S_SYNC;
        S_SYNC:  state_d = S_TTAR;
        S_TTAR:  state_d = S_IDLE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/nwt_capture.sv
module nwt_capture
  import nwt_pkg::*;
#(
  parameter int ADDR_NIBBLES = 7,
  localparam int ADDR_W = 4 * ADDR_NIBBLES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  nwt_state_e        state_i,
  input  logic [3:0]        bus_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        data_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else if (state_i == S_ADDR) addr_q <= {addr_q[ADDR_W-5:0], bus_i};
  end
  assign addr_o = addr_q;

  // lane 0 loads in the first data clock, lane 1 in the second
  for (genvar i = 0; i < 2; i++) begin : g_lane
    localparam nwt_state_e LOAD_ST = (i == 0) ? S_DLO : S_DHI;
    logic [3:0] nib_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) nib_q <= '0;
      else if (state_i == LOAD_ST) nib_q <= bus_i;
    end
    assign data_o[4*i +: 4] = nib_q;
  end
endmodule

// File: rtl/nwt_drive.sv
module nwt_drive
  import nwt_pkg::*;
(
  input  nwt_state_e state_i,
  output logic [3:0] bus_o,
  output logic       bus_oe_o,
  output logic       wr_valid_o
);
  always_comb begin
    bus_o      = NIB_ONES;
    bus_oe_o   = 1'b0;
    wr_valid_o = 1'b0;
    unique case (state_i)
      S_SYNC: begin
        bus_o      = SYNC_READY;
        bus_oe_o   = 1'b1;
        wr_valid_o = 1'b1;
      end
      S_TTAR:  bus_oe_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/nwt_target.sv
module nwt_target
  import nwt_pkg::*;
#(
  parameter int ADDR_NIBBLES = 7,
  localparam int ADDR_W = 4 * ADDR_NIBBLES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic [3:0]        bus_i,
  input  logic [3:0]        strap_i,
  output logic [3:0]        bus_o,
  output logic              bus_oe_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o
);
  nwt_state_e state;

  nwt_fsm #(.ADDR_NIBBLES(ADDR_NIBBLES)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_ni (frame_ni),
    .bus_i    (bus_i),
    .strap_i  (strap_i),
    .state_o  (state)
  );

  nwt_capture #(.ADDR_NIBBLES(ADDR_NIBBLES)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .bus_i   (bus_i),
    .addr_o  (wr_addr_o),
    .data_o  (wr_data_o)
  );

  nwt_drive u_drv (
    .state_i    (state),
    .bus_o      (bus_o),
    .bus_oe_o   (bus_oe_o),
    .wr_valid_o (wr_valid_o)
  );
endmodule

// File: rtl/nwt_checker.sv
module nwt_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_ni,
  input logic [3:0] bus_o,
  input logic       bus_oe_o,
  input logic       wr_valid_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_quiet_R1: assert (!bus_oe_o && !wr_valid_o);
  end

  assert_sync_value_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (bus_oe_o && bus_o == 4'h0));

  assert_strobe_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  assert_ones_after_sync_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && frame_ni) |=> (bus_oe_o && bus_o == 4'hF));

  assert_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o && !wr_valid_o) |=> !bus_oe_o);

  assert_restart_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ni |=> (!bus_oe_o && !wr_valid_o));
endmodule

bind nwt_target nwt_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_ni   (frame_ni),
  .bus_o      (bus_o),
  .bus_oe_o   (bus_oe_o),
  .wr_valid_o (wr_valid_o)
);

// File: tb/nwt_target_test.sv
module nwt_target_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        frame_n = 1'b1;
  logic        host_en = 1'b0;
  logic [3:0]  host_nib = 4'hF;
  logic [3:0]  strap = 4'h3;
  logic [3:0]  bus_o;
  logic        bus_oe, wv;
  logic [27:0] waddr;
  logic [7:0]  wdata;
  wire  [3:0]  bus_w = bus_oe ? bus_o : (host_en ? host_nib : 4'hF);

  int checks = 0, errors = 0, cycles = 0;
  logic [27:0] exp_addr;
  logic [7:0]  exp_data;

  always #5 clk = ~clk;

  nwt_target uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .bus_i(bus_w),
    .strap_i(strap), .bus_o(bus_o), .bus_oe_o(bus_oe), .wr_valid_o(wv),
    .wr_addr_o(waddr), .wr_data_o(wdata)
  );

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 5000", cycles);
      report();
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // compare outputs of the current clock, then drive this clock's inputs
  task automatic slot(input logic fr, input logic hen, input logic [3:0] hn,
                      input logic eoe, input logic [3:0] ebus, input logic ewv, input string req);
    @(negedge clk);
    chk(req, "bus_oe", 32'(bus_oe), 32'(eoe));
    chk(req, "wr_valid", 32'(wv), 32'(ewv));
    if (eoe) chk(req, "bus_o", 32'(bus_o), 32'(ebus));
    if (ewv) begin
      chk(req, "wr_addr", 32'(waddr), 32'(exp_addr));
      chk(req, "wr_data", 32'(wdata), 32'(exp_data));
    end
    frame_n = fr; host_en = hen; host_nib = hn;
  endtask

  task automatic frame_cycle(input int n_pre, input logic [3:0] pre_nib, input logic [3:0] last_start,
                             input logic [3:0] sel, input logic [27:0] addr, input logic [3:0] size,
                             input logic [7:0] data, input int cut, input string rtag);
    bit acc = (last_start == 4'hE) && (sel == strap);
    bit ok  = acc && (size == 4'h0);
    if (ok) begin exp_addr = addr; exp_data = data; end
    for (int i = 0; i < n_pre; i++) slot(1'b0, 1'b1, pre_nib, 1'b0, 4'h0, 1'b0, {rtag, " R2"});
    slot(1'b0, 1'b1, last_start, 1'b0, 4'h0, 1'b0, {rtag, " R2"});
    slot(1'b1, 1'b1, sel, 1'b0, 4'h0, 1'b0, {rtag, " R3"});
    for (int k = 0; k < 15; k++) begin
      logic [3:0] hn = 4'hF;
      logic hen = 1'b1, eoe = 1'b0, ewv = 1'b0;
      logic [3:0] eb = 4'h0;
      string t;
      if (k == cut) return;
      if (k < 7) begin hn = addr[4*(6-k) +: 4]; t = "R4"; end
      else if (k == 7) begin hn = size; t = "R5"; end
      else if (k == 8) begin hn = data[3:0]; t = "R6"; end
      else if (k == 9) begin hn = data[7:4]; t = "R6"; end
      else if (k == 10) begin hn = 4'hF; t = "R7"; end
      else begin
        hen = 1'b0;
        t = (k == 11) ? "R7" : (k == 12) ? "R8" : "R10";
      end
      if (ok && k == 12) begin eoe = 1'b1; eb = 4'h0; ewv = 1'b1; end
      if (ok && k == 13) begin eoe = 1'b1; eb = 4'hF; end
      slot(1'b1, hen, hn, eoe, eb, ewv, {rtag, " ", t});
    end
  endtask

  initial begin
    #2 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "bus_oe in reset", 32'(bus_oe), 32'd0);
    chk("R1", "wr_valid in reset", 32'(wv), 32'd0);
    rst_n = 1'b1;
    slot(1'b1, 1'b0, 4'hF, 1'b0, 4'h0, 1'b0, "R1");
    slot(1'b1, 1'b0, 4'hF, 1'b0, 4'h0, 1'b0, "R1");
    // R4 R6 R8: plain write
    frame_cycle(0, 4'h0, 4'hE, 4'h3, 28'h1234567, 4'h0, 8'hA5, -1, "basic");
    // R2: several start nibbles, last is the write code
    frame_cycle(2, 4'h2, 4'hE, 4'h3, 28'hFEDCBA9, 4'h0, 8'h3C, -1, "multi_start");
    // R2: write code first, other code last -> ignored
    frame_cycle(1, 4'hE, 4'hD, 4'h3, 28'h0A0A0A0, 4'h0, 8'h11, -1, "last_start_wins");
    // R3: select mismatch
    frame_cycle(0, 4'h0, 4'hE, 4'h5, 28'h7654321, 4'h0, 8'h22, -1, "sel_miss");
    // R5: bad size
    frame_cycle(0, 4'h0, 4'hE, 4'h3, 28'h0000FFF, 4'h1, 8'h33, -1, "size_bad");
    // R9: strobe reasserted during address, then a full write
    frame_cycle(0, 4'h0, 4'hE, 4'h3, 28'h5555555, 4'h0, 8'h44, 3, "cut R9");
    frame_cycle(0, 4'h0, 4'hE, 4'h3, 28'h89ABCDE, 4'h0, 8'h5A, -1, "restart R9");
    // R3: new strap, match and mismatch
    strap = 4'hC;
    frame_cycle(0, 4'h0, 4'hE, 4'hC, 28'h0000001, 4'h0, 8'hF0, -1, "strap_c R3");
    frame_cycle(0, 4'h0, 4'hE, 4'h3, 28'h0000002, 4'h0, 8'h0F, -1, "strap_c_miss R3");
    slot(1'b1, 1'b0, 4'hF, 1'b0, 4'h0, 1'b0, "R10");
    report();
  end
endmodule